// File: doc/BRIEF.md
# Microcontroller special function register file

This block is the special function register space of a small 8-bit microcontroller core. The core reaches it over an internal bus with an 8-bit direct address, a read strobe, a write strobe and 8-bit write data. Reads are combinational and arrive in the same cycle. Writes land on the next rising clock edge.

Behind the bus sit the following registers:
- the accumulator and the B register;
- the status byte;
- the stack pointer;
- the two halves of the data pointer;
- four port output latches;
- a serial buffer address. It maps to two physical registers: a transmit holding register, which is written, and a receive register, which is read.

Side-band ports let the core do the rest of its work without the bus:
- push and pop the stack, getting back the data-memory address to use;
- load or increment the data pointer as one 16-bit value;
- write a multiply/divide result pair into the accumulator and B;
- hand bytes to a serial transmitter, and take bytes from a receiver.

None of these ports uses back-pressure. A transmit start is a one-cycle pulse, and the core paces transmissions itself. A received byte offered with `rx_valid` is always taken, and it overwrites the previous one.

Top module: `sfr_bank`

## Requirements
- R1: After reset the stack pointer reads 07H and all four port latches read FFH. The accumulator, B, status byte, data pointer, transmit register and receive register are 00H, and `tx_start` is low.
- R2: While `stk_push` is high, `stk_addr` equals the stack pointer plus one, wrapping FFH to 00H. After the edge, the stack pointer holds that value.
- R3: While `stk_pop` is high and `stk_push` is low, `stk_addr` equals the current stack pointer. After the edge, the stack pointer is one lower, wrapping 00H to FFH. When both are high, only the push takes effect.
- R4: A bus write to the stack pointer (81H) in the same cycle as a push or pop sets the stack pointer to the bus data.
- R5: The data pointer low byte (82H) and high byte (83H) are written and read on their own. The `dptr` output is {high, low}.
- R6: `dptr_load` loads `dptr_load_val`. `dptr_inc` adds one to the 16-bit pair, with carry from the low byte into the high byte and FFFFH wrapping to 0000H. If both are high, the load takes effect.
- R7: A bus write to either data pointer byte cancels any 16-bit load or increment in that cycle. The written byte takes the bus data and the other byte keeps its value.
- R8: A write to the serial buffer address (99H) loads `tx_data`. `tx_start` is then high for exactly the one cycle after the write edge.
- R9: A read of 99H returns the last byte taken with `rx_valid`, never the transmit byte.
- R10: A write to any address outside the implemented set changes no register, and a read of such an address returns the parameter `UNMAPPED_VAL` (default 00H). The implemented set is 80H, 81H, 82H, 83H, 90H, 99H, A0H, B0H, D0H, E0H and F0H.
- R11: `md_wr` loads `md_acc` into the accumulator (E0H) and `md_b` into B (F0H). A bus write to either of those registers in the same cycle takes precedence for that register.
- R12: Bit 0 of the status byte (D0H), read on the bus and seen on `psw`, is the XOR of the accumulator bits. A write to bit 0 is ignored, and bits 7 to 1 store the written data.
- R13: The port latches are at 80H, 90H, A0H and B0H. A write sets the latch, a read returns it, and `port_q` carries latch i in bits [8i+7:8i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Direct address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, zero when no read |
| stk_push | input | 1 | Push request |
| stk_pop | input | 1 | Pop request |
| stk_addr | output | 8 | Data-memory address for the current push or pop |
| sp | output | 8 | Stack pointer |
| dptr_inc | input | 1 | Increment data pointer |
| dptr_load | input | 1 | Load data pointer |
| dptr_load_val | input | 16 | Value to load |
| dptr | output | 16 | Data pointer {high, low} |
| md_wr | input | 1 | Multiply/divide result write |
| md_acc | input | 8 | Result byte for the accumulator |
| md_b | input | 8 | Result byte for B |
| acc | output | 8 | Accumulator |
| b | output | 8 | B register |
| psw | output | 8 | Status byte with the parity bit |
| port_q | output | 32 | Port latches 0 to 3 |
| tx_data | output | 8 | Transmit holding register |
| tx_start | output | 1 | One-cycle transmission start |
| rx_valid | input | 1 | Received byte present |
| rx_data | input | 8 | Received byte |

## Verification
Each result has its own due time:
- Bus read data, `stk_addr` and the parity bit depend only on the current inputs and register state, so they are due in the same cycle as the stimulus.
- Register contents are due after one rising edge.
- `tx_start` is due in the cycle right after the write edge, and must be low again in the cycle after that.

The bench drives every input on the falling edge and samples 1 ns later. A read or address check therefore sees the state settled by the last rising edge plus the current combinational path, and the pulse checks land on the two cycles that follow a serial buffer write.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
  localparam int BYTE_W = 8;

  localparam logic [7:0] ADR_SP   = 8'h81;
  localparam logic [7:0] ADR_DLO  = 8'h82;
  localparam logic [7:0] ADR_DHI  = 8'h83;
  localparam logic [7:0] ADR_SER  = 8'h99;
  localparam logic [7:0] ADR_STAT = 8'hD0;
  localparam logic [7:0] ADR_ACC  = 8'hE0;
  localparam logic [7:0] ADR_B    = 8'hF0;
  localparam logic [7:0] ADR_PORT_BASE = 8'h80;
  localparam int         PORT_STRIDE   = 16;

  function automatic logic [7:0] port_addr(input int idx);
    return 8'(int'(ADR_PORT_BASE) + idx * PORT_STRIDE);
  endfunction
endpackage

// File: rtl/sfr_stack.sv
module sfr_stack #(
  parameter int W = 8,
  parameter logic [W-1:0] RST_VAL = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] sp_o,
  output logic [W-1:0] addr_o
);
  logic [W-1:0] sp_q;
  logic [W-1:0] sp_up;
  logic [W-1:0] sp_dn;

  assign sp_up  = sp_q + W'(1);
  assign sp_dn  = sp_q - W'(1);
  // push uses the incremented pointer, pop uses the current one
  assign addr_o = push ? sp_up : sp_q;
  assign sp_o   = sp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sp_q <= RST_VAL;
    else if (wr)   sp_q <= wdata;
    else if (push) sp_q <= sp_up;
    else if (pop)  sp_q <= sp_dn;
  end

  a_r2_push_advances: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !wr) |=> (sp_o == $past(addr_o)));
  a_r3_pop_retreats: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && !wr) |=> (sp_o == $past(sp_o) - W'(1)));
  a_r4_bus_overrides: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (sp_o == $past(wdata)));
endmodule

// File: rtl/sfr_dptr.sv
module sfr_dptr #(
  parameter int W = 16,
  localparam int HW = W / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [HW-1:0] wdata,
  input  logic          load,
  input  logic [W-1:0]  load_val,
  input  logic          inc,
  output logic [W-1:0]  dptr_o
);
  logic [HW-1:0] lo_q, hi_q;
  logic [W-1:0]  wide_next;
  logic          byte_wr;
  logic          wide_upd;

  assign byte_wr   = wr_lo || wr_hi;
  assign wide_upd  = (load || inc) && !byte_wr;
  assign wide_next = load ? load_val : ({hi_q, lo_q} + W'(1));
  assign dptr_o    = {hi_q, lo_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (byte_wr) begin
      if (wr_lo) lo_q <= wdata;
      if (wr_hi) hi_q <= wdata;
    end else if (wide_upd) begin
      {hi_q, lo_q} <= wide_next;
    end
  end

  a_r6_inc_carries: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !load && !byte_wr) |=> (dptr_o == $past(dptr_o) + W'(1)));
  a_r6_load_first: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !byte_wr) |=> (dptr_o == $past(load_val)));
  a_r7_byte_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && !wr_hi) |=> (dptr_o[W-1:HW] == $past(dptr_o[W-1:HW])));
endmodule

// File: rtl/sfr_serial.sv
module sfr_serial #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         rx_valid,
  input  logic [W-1:0] rx_data,
  output logic [W-1:0] tx_data_o,
  output logic         tx_start_o,
  output logic [W-1:0] rx_q_o
);
  logic [W-1:0] tx_q, rx_q;
  logic         start_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q    <= '0;
      rx_q    <= '0;
      start_q <= 1'b0;
    end else begin
      start_q <= wr;
      if (wr)       tx_q <= wdata;
      if (rx_valid) rx_q <= rx_data;
    end
  end

  assign tx_data_o  = tx_q;
  assign tx_start_o = start_q;
  assign rx_q_o     = rx_q;

  a_r8_pulse_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (tx_start_o && tx_data_o == $past(wdata)));
  a_r8_pulse_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> !tx_start_o);
  a_r9_rx_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> $stable(rx_q_o));
endmodule

// File: rtl/sfr_ports.sv
module sfr_ports #(
  parameter int N = 4,
  parameter int W = 8,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   wr_sel,
  input  logic [W-1:0]   wdata,
  output logic [N*W-1:0] q_o
);
  for (genvar i = 0; i < N; i++) begin : g_latch
    logic [W-1:0] lat_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        lat_q <= RST_VAL;
      else if (wr_sel[i]) lat_q <= wdata;
    end
    assign q_o[i*W +: W] = lat_q;
  end

  a_r13_single_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_sel));
endmodule

// File: rtl/sfr_bank.sv
module sfr_bank
  import sfr_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter logic [7:0] UNMAPPED_VAL = 8'h00,
  parameter logic [7:0] SP_RESET = 8'h07,
  parameter logic [7:0] PORT_RESET = 8'hFF,
  localparam int DW = BYTE_W,
  localparam int PW = NUM_PORTS * BYTE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    bus_addr,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          stk_push,
  input  logic          stk_pop,
  output logic [DW-1:0] stk_addr,
  output logic [DW-1:0] sp,
  input  logic          dptr_inc,
  input  logic          dptr_load,
  input  logic [2*DW-1:0] dptr_load_val,
  output logic [2*DW-1:0] dptr,
  input  logic          md_wr,
  input  logic [DW-1:0] md_acc,
  input  logic [DW-1:0] md_b,
  output logic [DW-1:0] acc,
  output logic [DW-1:0] b,
  output logic [DW-1:0] psw,
  output logic [PW-1:0] port_q,
  output logic [DW-1:0] tx_data,
  output logic          tx_start,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data
);
  logic [DW-1:0] acc_q, b_q;
  logic [DW-1:1] stat_q;
  logic [DW-1:0] rx_q;
  logic [NUM_PORTS-1:0] port_wsel;
  logic wr_sp, wr_dlo, wr_dhi, wr_ser, wr_stat, wr_acc, wr_b;
  logic port_hit, mapped;
  logic [DW-1:0] rd_mux;

  assign wr_sp   = bus_wr && (bus_addr == ADR_SP);
  assign wr_dlo  = bus_wr && (bus_addr == ADR_DLO);
  assign wr_dhi  = bus_wr && (bus_addr == ADR_DHI);
  assign wr_ser  = bus_wr && (bus_addr == ADR_SER);
  assign wr_stat = bus_wr && (bus_addr == ADR_STAT);
  assign wr_acc  = bus_wr && (bus_addr == ADR_ACC);
  assign wr_b    = bus_wr && (bus_addr == ADR_B);

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_pdec
    assign port_wsel[i] = bus_wr && (bus_addr == port_addr(i));
  end

  always_comb begin
    port_hit = 1'b0;
    for (int i = 0; i < NUM_PORTS; i++)
      if (bus_addr == port_addr(i)) port_hit = 1'b1;
  end

  assign mapped = port_hit || (bus_addr == ADR_SP) || (bus_addr == ADR_DLO) ||
                  (bus_addr == ADR_DHI) || (bus_addr == ADR_SER) ||
                  (bus_addr == ADR_STAT) || (bus_addr == ADR_ACC) ||
                  (bus_addr == ADR_B);

  // accumulator, B and status byte
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      b_q    <= '0;
      stat_q <= '0;
    end else begin
      if (wr_acc)     acc_q <= bus_wdata;
      else if (md_wr) acc_q <= md_acc;
      if (wr_b)       b_q   <= bus_wdata;
      else if (md_wr) b_q   <= md_b;
      if (wr_stat)    stat_q <= bus_wdata[DW-1:1];
    end
  end

  assign acc = acc_q;
  assign b   = b_q;
  assign psw = {stat_q, ^acc_q};

  sfr_stack #(.W(DW), .RST_VAL(SP_RESET)) u_stack (
    .clk(clk), .rst_n(rst_n), .push(stk_push), .pop(stk_pop),
    .wr(wr_sp), .wdata(bus_wdata), .sp_o(sp), .addr_o(stk_addr)
  );

  sfr_dptr #(.W(2*DW)) u_dptr (
    .clk(clk), .rst_n(rst_n), .wr_lo(wr_dlo), .wr_hi(wr_dhi),
    .wdata(bus_wdata), .load(dptr_load), .load_val(dptr_load_val),
    .inc(dptr_inc), .dptr_o(dptr)
  );

  sfr_serial #(.W(DW)) u_serial (
    .clk(clk), .rst_n(rst_n), .wr(wr_ser), .wdata(bus_wdata),
    .rx_valid(rx_valid), .rx_data(rx_data), .tx_data_o(tx_data),
    .tx_start_o(tx_start), .rx_q_o(rx_q)
  );

  sfr_ports #(.N(NUM_PORTS), .W(DW), .RST_VAL(PORT_RESET)) u_ports (
    .clk(clk), .rst_n(rst_n), .wr_sel(port_wsel), .wdata(bus_wdata),
    .q_o(port_q)
  );

  always_comb begin
    rd_mux = UNMAPPED_VAL;
    unique case (bus_addr)
      ADR_SP:   rd_mux = sp;
      ADR_DLO:  rd_mux = dptr[DW-1:0];
      ADR_DHI:  rd_mux = dptr[2*DW-1:DW];
      ADR_SER:  rd_mux = rx_q;
      ADR_STAT: rd_mux = psw;
      ADR_ACC:  rd_mux = acc_q;
      ADR_B:    rd_mux = b_q;
      default:  rd_mux = UNMAPPED_VAL;
    endcase
    for (int i = 0; i < NUM_PORTS; i++)
      if (bus_addr == port_addr(i)) rd_mux = port_q[i*DW +: DW];
  end

  assign bus_rdata = bus_rd ? rd_mux : '0;

  a_r10_stray_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !mapped && !md_wr) |=>
      ($stable(acc_q) && $stable(b_q) && $stable(stat_q) && $stable(port_q)));
  a_r11_md_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (md_wr && !wr_acc && !wr_b) |=> (acc == $past(md_acc) && b == $past(md_b)));
  a_r11_bus_beats_md: assert property (@(posedge clk) disable iff (!rst_n)
    wr_acc |=> (acc == $past(bus_wdata)));
  a_r12_parity_follows: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(acc) % 2 == 1) == psw[0]);
endmodule

// File: tb/sfr_bank_tb.sv
`timescale 1ns/1ps
module sfr_bank_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] bus_addr = '0, bus_wdata = '0, bus_rdata;
  logic bus_rd = 0, bus_wr = 0, stk_push = 0, stk_pop = 0;
  logic [7:0] stk_addr, sp;
  logic dptr_inc = 0, dptr_load = 0;
  logic [15:0] dptr_load_val = '0, dptr;
  logic md_wr = 0;
  logic [7:0] md_acc = '0, md_b = '0, acc, b, psw, tx_data, rx_data = '0;
  logic [31:0] port_q;
  logic tx_start, rx_valid = 0;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sfr_bank u_dut (.*);

  // bench model of the register contents
  logic [7:0] m_acc, m_b, m_stat, m_sp, m_dlo, m_dhi, m_rx;
  logic [7:0] m_p [4];

  function automatic logic [7:0] exp_rd(input logic [7:0] a);
    case (a)
      8'h80: return m_p[0];
      8'h90: return m_p[1];
      8'hA0: return m_p[2];
      8'hB0: return m_p[3];
      8'h81: return m_sp;
      8'h82: return m_dlo;
      8'h83: return m_dhi;
      8'h99: return m_rx;
      8'hD0: return {m_stat[7:1], ^m_acc};
      8'hE0: return m_acc;
      8'hF0: return m_b;
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_wr(input logic [7:0] a, input logic [7:0] d);
    case (a)
      8'h80: m_p[0] = d;
      8'h90: m_p[1] = d;
      8'hA0: m_p[2] = d;
      8'hB0: m_p[3] = d;
      8'h81: m_sp = d;
      8'h82: m_dlo = d;
      8'h83: m_dhi = d;
      8'hD0: m_stat = d;
      8'hE0: m_acc = d;
      8'hF0: m_b = d;
      default: ;
    endcase
  endtask

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic bus_read(input logic [7:0] a, input string req, input logic [7:0] exp);
    @(negedge clk);
    bus_addr = a; bus_rd = 1;
    #1;
    check(req, bus_rdata, exp);
    bus_rd = 0;
  endtask

  function automatic logic [7:0] pick_addr(input int unsigned r);
    logic [7:0] lst [12] = '{8'h80, 8'h81, 8'h82, 8'h83, 8'h90, 8'h99,
                             8'hA0, 8'hB0, 8'hD0, 8'hE0, 8'hF0, 8'h00};
    int k = int'(r % 12);
    if (k == 11) return 8'((r >> 8) & 8'hFF);
    return lst[k];
  endfunction

  initial begin
    logic [7:0] a, d;
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    m_acc = 0; m_b = 0; m_stat = 0; m_sp = 8'h07; m_dlo = 0; m_dhi = 0; m_rx = 0;
    for (int i = 0; i < 4; i++) m_p[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    bus_read(8'h81, "R1 sp reset", 8'h07);
    @(negedge clk); #1;
    check("R1 ports reset", port_q[15:0], 16'hFFFF);
    check("R1 ports reset hi", port_q[31:16], 16'hFFFF);
    check("R1 acc/b reset", {acc, b}, 16'h0000);
    check("R1 dptr reset", dptr, 16'h0000);
    check("R1 tx_start low", {7'd0, tx_start}, 16'h0000);

    // R2 push from reset value
    @(negedge clk); stk_push = 1; #1;
    check("R2 push addr", stk_addr, 8'h08);
    @(negedge clk); stk_push = 0;
    bus_read(8'h81, "R2 sp after push", 8'h08);
    // R2 wrap
    bus_write(8'h81, 8'hFF);
    stk_push = 1; #1;
    check("R2 push wrap addr", stk_addr, 8'h00);
    @(negedge clk); stk_push = 0; #1;
    check("R2 sp wraps", sp, 8'h00);
    // R3 pop wrap
    stk_pop = 1; #1;
    check("R3 pop addr", stk_addr, 8'h00);
    @(negedge clk); stk_pop = 0; #1;
    check("R3 sp wraps down", sp, 8'hFF);
    // R3 push and pop together
    stk_push = 1; stk_pop = 1;
    @(negedge clk); stk_push = 0; stk_pop = 0; #1;
    check("R3 push wins over pop", sp, 8'h00);
    // R4 bus write beats push
    bus_addr = 8'h81; bus_wdata = 8'h40; bus_wr = 1; stk_push = 1;
    @(negedge clk); bus_wr = 0; stk_push = 0; #1;
    check("R4 bus write over push", sp, 8'h40);
    m_sp = 8'h40;

    // R5 byte writes
    bus_write(8'h82, 8'hFF);
    bus_write(8'h83, 8'h12);
    #1; check("R5 dptr bytes", dptr, 16'h12FF);
    bus_read(8'h83, "R5 high byte read", 8'h12);
    // R6 increment with carry
    @(negedge clk); dptr_inc = 1;
    @(negedge clk); dptr_inc = 0; #1;
    check("R6 inc carry", dptr, 16'h1300);
    dptr_load = 1; dptr_load_val = 16'hFFFF;
    @(negedge clk); dptr_load = 0; dptr_inc = 1;
    @(negedge clk); dptr_inc = 0; #1;
    check("R6 inc wraps", dptr, 16'h0000);
    dptr_load = 1; dptr_inc = 1; dptr_load_val = 16'hBEEF;
    @(negedge clk); dptr_load = 0; dptr_inc = 0; #1;
    check("R6 load over inc", dptr, 16'hBEEF);
    // R7 byte write cancels wide update
    bus_addr = 8'h82; bus_wdata = 8'h40; bus_wr = 1; dptr_inc = 1;
    @(negedge clk); bus_wr = 0; dptr_inc = 0; #1;
    check("R7 byte write wins", dptr, 16'hBE40);
    m_dlo = 8'h40; m_dhi = 8'hBE;

    // R8 transmit
    bus_write(8'h99, 8'h5A);
    #1;
    check("R8 tx_start pulse", {7'd0, tx_start}, 16'h0001);
    check("R8 tx_data", tx_data, 8'h5A);
    @(negedge clk); #1;
    check("R8 tx_start drops", {7'd0, tx_start}, 16'h0000);
    // R9 receive
    @(negedge clk); rx_valid = 1; rx_data = 8'hC3;
    @(negedge clk); rx_valid = 0;
    m_rx = 8'hC3;
    bus_read(8'h99, "R9 read returns rx", 8'hC3);
    check("R9 tx untouched", tx_data, 8'h5A);

    // R11 multiply/divide port and precedence
    @(negedge clk); md_wr = 1; md_acc = 8'h07; md_b = 8'h21;
    @(negedge clk); md_wr = 0; #1;
    check("R11 md write", {acc, b}, 16'h0721);
    // R12 parity of 07H is 1
    check("R12 parity bit", {15'd0, psw[0]}, 16'h0001);
    bus_addr = 8'hE0; bus_wdata = 8'h03; bus_wr = 1;
    md_wr = 1; md_acc = 8'hAA; md_b = 8'h55;
    @(negedge clk); bus_wr = 0; md_wr = 0; #1;
    check("R11 bus beats md on acc", {acc, b}, 16'h0355);
    m_acc = 8'h03; m_b = 8'h55;
    // R12 bit 0 write ignored
    bus_write(8'hD0, 8'hF1);
    m_stat = 8'hF1;
    bus_read(8'hD0, "R12 status readback", 8'hF0);

    // R10 unmapped write then read
    bus_write(8'h84, 8'h77);
    bus_read(8'h84, "R10 unmapped read", 8'h00);
    #1; check("R10 no effect on acc/b", {acc, b}, 16'h0355);

    // R13 port latch at A0H lands in bits 23:16
    bus_write(8'hA0, 8'h3C);
    m_p[2] = 8'h3C;
    #1; check("R13 port_q field", port_q[23:16], 8'h3C);

    // random mix: R5,R10,R12,R13 readback against model
    for (int it = 0; it < 300; it++) begin
      a = pick_addr($urandom);
      d = 8'($urandom);
      bus_write(a, d);
      model_wr(a, d);
      if (a == 8'h99) begin
        #1; check("R8 random tx", {7'd0, tx_start, tx_data}, {8'h01, d});
      end
      a = pick_addr($urandom);
      bus_read(a, "R5,R10,R12,R13 random readback", exp_rd(a));
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule